// File: doc/BRIEF.md
# Ordered Message FIFO Channel

This block carries words from one sender to one receiver through a single first-in, first-out queue whose depth is a parameter. The sender writes words back to back, with no need to wait for any reply, for as long as free slots remain. The receiver sees the oldest word on its data output and takes it with a pop strobe. Words always leave in the order they arrived.

Each word travels with a flag that asks for a reply. After the receiver pops a flagged word, it can send an acknowledge strobe. That strobe raises a sticky indication on the sender side.

Watermark interrupts track the fill level against two thresholds that software programs: a rising mark and a falling mark. A flush strobe discards the whole contents in one cycle and latches a completion flag. A transfer-pending level tells the receiver that data is waiting. Sticky flags record refused writes and reads of an empty queue. Every interrupt output is a level and stays asserted as long as its condition holds. The depth is exposed as a constant output so that software can read it at run time.

Top module: `msg_fifo_chan`

## Requirements
- R1: While `rst_n` is low and after its release, `occupancy` is 0, `irq_rcv_xfer`, `irq_flush`, `irq_snd_ack`, `sts_overflow` and `sts_underflow` are 0, and `depth_o` always equals the DEPTH parameter.
- R2: Words are delivered in write order. While the queue is not empty, `rcv_data` and `rcv_ack_req` show the oldest word and its reply flag. A pop removes that word at the next clock edge, and `occupancy` drops by one.
- R3: A write while `occupancy` equals DEPTH is refused. The queue contents and `occupancy` stay unchanged, and `sts_overflow` is set. It stays set until `clr_overflow` is pulsed.
- R4: While the queue is empty, `rcv_data` reads 0. A pop while empty leaves `occupancy` at 0 and sets `sts_underflow`, which stays set until `clr_underflow` is pulsed.
- R5: `irq_high_tide` is 1 exactly while `occupancy` >= `cfg_high_tide`.
- R6: `irq_low_tide` is 1 exactly while `occupancy` <= `cfg_low_tide`.
- R7: A `flush_req` cycle empties the queue at the next edge, whatever push or pop arrives in the same cycle. It sets the flush-done flag, which drives `irq_flush` high until `clr_flush_done` is pulsed.
- R8: `irq_rcv_xfer` is 1 exactly while `occupancy` is nonzero.
- R9: A `rcv_ack` pulse that follows the pop of a word written with `snd_ack_req`=1 sets `irq_snd_ack` at the next edge. It stays set until `clr_snd_ack` is pulsed. An acknowledge after popping an unflagged word has no effect, and only the first acknowledge of a popped word counts.
- R10: A write and a pop in the same cycle, on a queue that is neither full nor empty, both take effect. `occupancy` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_push | input | 1 | Sender write strobe |
| snd_data | input | DATA_W | Sender word |
| snd_ack_req | input | 1 | Request a reply for this word |
| snd_full | output | 1 | Queue has no free slot |
| rcv_pop | input | 1 | Receiver pop strobe |
| rcv_data | output | DATA_W | Oldest word, 0 when empty |
| rcv_ack_req | output | 1 | Reply flag of the oldest word |
| rcv_ack | input | 1 | Acknowledge the last popped word |
| flush_req | input | 1 | Discard all contents |
| cfg_high_tide | input | CNT_W | Rising watermark |
| cfg_low_tide | input | CNT_W | Falling watermark |
| clr_overflow | input | 1 | Clear overflow flag |
| clr_underflow | input | 1 | Clear underflow flag |
| clr_flush_done | input | 1 | Clear flush-done flag |
| clr_snd_ack | input | 1 | Clear sender reply flag |
| occupancy | output | CNT_W | Words held |
| depth_o | output | CNT_W | Queue depth constant |
| sts_overflow | output | 1 | Sticky refused-write flag |
| sts_underflow | output | 1 | Sticky empty-pop flag |
| irq_high_tide | output | 1 | Fill at or above rising mark |
| irq_low_tide | output | 1 | Fill at or below falling mark |
| irq_flush | output | 1 | Flush completed |
| irq_rcv_xfer | output | 1 | Data waiting for receiver |
| irq_snd_ack | output | 1 | Reply received by sender |

## Verification
The bench builds the block with DEPTH=4 and DATA_W=8. The small depth makes the full boundary and the refused fifth write reachable in a few cycles. It also makes the read pointer wrap around during the ordering and simultaneous push-and-pop tests. With thresholds of 3 and 1, every fill level from 0 to 4 falls on a distinct side of one mark or the other, so both watermark comparisons are checked at their exact edges.

// File: rtl/msg_fifo_chan.sv
module msg_fifo_chan #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_push,
  input  logic [DATA_W-1:0] snd_data,
  input  logic              snd_ack_req,
  output logic              snd_full,
  input  logic              rcv_pop,
  output logic [DATA_W-1:0] rcv_data,
  output logic              rcv_ack_req,
  input  logic              rcv_ack,
  input  logic              flush_req,
  input  logic [CNT_W-1:0]  cfg_high_tide,
  input  logic [CNT_W-1:0]  cfg_low_tide,
  input  logic              clr_overflow,
  input  logic              clr_underflow,
  input  logic              clr_flush_done,
  input  logic              clr_snd_ack,
  output logic [CNT_W-1:0]  occupancy,
  output logic [CNT_W-1:0]  depth_o,
  output logic              sts_overflow,
  output logic              sts_underflow,
  output logic              irq_high_tide,
  output logic              irq_low_tide,
  output logic              irq_flush,
  output logic              irq_rcv_xfer,
  output logic              irq_snd_ack
);

  logic [DATA_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             empty, push_ok, pop_ok, last_ack, flush_done, snd_ack;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign snd_full = (count == CNT_W'(DEPTH));
  assign push_ok  = snd_push & ~snd_full & ~flush_req;
  assign pop_ok   = rcv_pop & ~empty & ~flush_req;

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr] <= {snd_ack_req, snd_data};

  always_ff @(posedge clk) begin
    if (!rst_n || flush_req) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_req) last_ack <= 1'b0;
    else if (pop_ok)         last_ack <= mem[rd_ptr][DATA_W];
    else if (rcv_pop)        last_ack <= 1'b0;
    else if (rcv_ack)        last_ack <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_overflow  <= 1'b0;
      sts_underflow <= 1'b0;
      flush_done    <= 1'b0;
      snd_ack       <= 1'b0;
    end else begin
      if (snd_push && snd_full && !flush_req) sts_overflow <= 1'b1;
      else if (clr_overflow)                  sts_overflow <= 1'b0;
      if (rcv_pop && empty && !flush_req)     sts_underflow <= 1'b1;
      else if (clr_underflow)                 sts_underflow <= 1'b0;
      if (flush_req)                          flush_done <= 1'b1;
      else if (clr_flush_done)                flush_done <= 1'b0;
      if (rcv_ack && last_ack)                snd_ack <= 1'b1;
      else if (clr_snd_ack)                   snd_ack <= 1'b0;
    end
  end

  assign rcv_data      = empty ? '0 : mem[rd_ptr][DATA_W-1:0];
  assign rcv_ack_req   = ~empty & mem[rd_ptr][DATA_W];
  assign occupancy     = count;
  assign depth_o       = CNT_W'(DEPTH);
  assign irq_high_tide = (count >= cfg_high_tide);
  assign irq_low_tide  = (count <= cfg_low_tide);
  assign irq_flush     = flush_done;
  assign irq_rcv_xfer  = ~empty;
  assign irq_snd_ack   = snd_ack;

endmodule

// File: rtl/msg_fifo_chan_chk.sv
module msg_fifo_chan_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snd_push,
  input logic              rcv_pop,
  input logic              flush_req,
  input logic              clr_overflow,
  input logic              clr_underflow,
  input logic              clr_snd_ack,
  input logic [CNT_W-1:0]  occupancy,
  input logic [DATA_W-1:0] rcv_data,
  input logic              sts_overflow,
  input logic              sts_underflow,
  input logic              irq_flush,
  input logic              irq_snd_ack
);

  AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH) && snd_push && !flush_req) |=> sts_overflow); // R3

  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH) && snd_push && !rcv_pop && !flush_req) |=> occupancy == CNT_W'(DEPTH)); // R3

  AST_OVERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_overflow && !clr_overflow) |=> sts_overflow); // R3

  AST_EMPTY_POP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && rcv_pop && !flush_req) |=> sts_underflow); // R4

  AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_underflow && !clr_underflow) |=> sts_underflow); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (occupancy == '0 && irq_flush && rcv_data == '0)); // R7

  AST_SND_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_snd_ack && !clr_snd_ack) |=> irq_snd_ack); // R9

  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_req |=> ({1'b0, occupancy} <= {1'b0, $past(occupancy)} + 1'b1)); // R2

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH)); // R2

endmodule

bind msg_fifo_chan msg_fifo_chan_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .snd_push(snd_push), .rcv_pop(rcv_pop),
  .flush_req(flush_req), .clr_overflow(clr_overflow), .clr_underflow(clr_underflow),
  .clr_snd_ack(clr_snd_ack), .occupancy(occupancy), .rcv_data(rcv_data),
  .sts_overflow(sts_overflow), .sts_underflow(sts_underflow),
  .irq_flush(irq_flush), .irq_snd_ack(irq_snd_ack)
);

// File: tb/msg_fifo_chan_bench.sv
module msg_fifo_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DP = 4;
  localparam int CW = $clog2(DP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic snd_push = 0, snd_ack_req = 0, rcv_pop = 0, rcv_ack = 0, flush_req = 0;
  logic clr_overflow = 0, clr_underflow = 0, clr_flush_done = 0, clr_snd_ack = 0;
  logic [DW-1:0] snd_data = '0;
  logic [CW-1:0] cfg_high_tide = CW'(3), cfg_low_tide = CW'(1);
  logic snd_full, rcv_ack_req, sts_overflow, sts_underflow;
  logic irq_high_tide, irq_low_tide, irq_flush, irq_rcv_xfer, irq_snd_ack;
  logic [DW-1:0] rcv_data;
  logic [CW-1:0] occupancy, depth_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_fifo_chan #(.DATA_W(DW), .DEPTH(DP)) u_msg_fifo_chan (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #(CLK_PERIOD/4);
    snd_push = 0; snd_ack_req = 0; rcv_pop = 0; rcv_ack = 0; flush_req = 0;
    clr_overflow = 0; clr_underflow = 0; clr_flush_done = 0; clr_snd_ack = 0;
  endtask

  task automatic push(int d, bit a);
    snd_push = 1; snd_data = DW'(d); snd_ack_req = a; cyc();
  endtask

  task automatic pop_expect(string req, int d);
    chk(req, "head word", rcv_data, d);
    rcv_pop = 1; cyc();
  endtask

  task automatic t_reset();
    chk("R1", "occupancy", occupancy, 0);
    chk("R1", "xfer irq", irq_rcv_xfer, 0);
    chk("R1", "flush irq", irq_flush, 0);
    chk("R1", "ack irq", irq_snd_ack, 0);
    chk("R1", "overflow", sts_overflow, 0);
    chk("R1", "underflow", sts_underflow, 0);
    chk("R1", "depth", depth_o, DP);
  endtask

  task automatic t_order();
    push(8'h11, 0); push(8'h22, 0); push(8'h33, 0);
    chk("R2", "occupancy after 3", occupancy, 3);
    chk("R8", "xfer irq", irq_rcv_xfer, 1);
    pop_expect("R2", 8'h11);
    snd_push = 1; snd_data = 8'h44; rcv_pop = 1;
    chk("R10", "head before dual", rcv_data, 8'h22);
    cyc();
    chk("R10", "occupancy after dual", occupancy, 2);
    pop_expect("R2", 8'h33);
    pop_expect("R2", 8'h44);
    chk("R2", "drained", occupancy, 0);
    chk("R8", "xfer irq idle", irq_rcv_xfer, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DP; i++) push(8'hA0 + i, 0);
    chk("R3", "full flag", snd_full, 1);
    push(8'hEE, 0);
    chk("R3", "occupancy stays", occupancy, DP);
    chk("R3", "overflow set", sts_overflow, 1);
    cyc();
    chk("R3", "overflow sticky", sts_overflow, 1);
    clr_overflow = 1; cyc();
    chk("R3", "overflow cleared", sts_overflow, 0);
    for (int i = 0; i < DP; i++) pop_expect("R3", 8'hA0 + i);
    chk("R3", "no refused word", occupancy, 0);
  endtask

  task automatic t_underflow();
    chk("R4", "empty reads zero", rcv_data, 0);
    rcv_pop = 1; cyc();
    chk("R4", "underflow set", sts_underflow, 1);
    chk("R4", "occupancy stays", occupancy, 0);
    clr_underflow = 1; cyc();
    chk("R4", "underflow cleared", sts_underflow, 0);
  endtask

  task automatic t_tide();
    for (int n = 0; n <= DP; n++) begin
      chk("R5", $sformatf("high tide at %0d", n), irq_high_tide, n >= 3);
      chk("R6", $sformatf("low tide at %0d", n), irq_low_tide, n <= 1);
      if (n < DP) push(n, 0);
    end
    cfg_high_tide = CW'(DP + 1); cfg_low_tide = CW'(DP);
    #1;
    chk("R5", "high tide above depth", irq_high_tide, 0);
    chk("R6", "low tide at depth", irq_low_tide, 1);
    cfg_high_tide = CW'(3); cfg_low_tide = CW'(1);
    flush_req = 1; cyc();
    clr_flush_done = 1; cyc();
  endtask

  task automatic t_flush();
    push(1, 0); push(2, 0); push(3, 0);
    flush_req = 1; snd_push = 1; snd_data = 8'h77; rcv_pop = 1; cyc();
    chk("R7", "emptied", occupancy, 0);
    chk("R7", "flush irq", irq_flush, 1);
    chk("R7", "no underflow from pop", sts_underflow, 0);
    cyc();
    chk("R7", "flush irq held", irq_flush, 1);
    clr_flush_done = 1; cyc();
    chk("R7", "flush irq cleared", irq_flush, 0);
    push(8'h5A, 0);
    pop_expect("R7", 8'h5A);
  endtask

  task automatic t_ack();
    push(8'hC1, 1); push(8'hC2, 0);
    chk("R9", "head reply flag", rcv_ack_req, 1);
    pop_expect("R9", 8'hC1);
    chk("R9", "no ack yet", irq_snd_ack, 0);
    rcv_ack = 1; cyc();
    chk("R9", "ack raised", irq_snd_ack, 1);
    cyc();
    chk("R9", "ack held", irq_snd_ack, 1);
    clr_snd_ack = 1; cyc();
    chk("R9", "ack cleared", irq_snd_ack, 0);
    pop_expect("R9", 8'hC2);
    rcv_ack = 1; cyc();
    chk("R9", "unflagged ignored", irq_snd_ack, 0);
    push(8'hC3, 1);
    pop_expect("R9", 8'hC3);
    rcv_ack = 1; cyc();
    clr_snd_ack = 1; cyc();
    rcv_ack = 1; cyc();
    chk("R9", "second ack ignored", irq_snd_ack, 0);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst_n = 1;
    cyc();
    t_reset();
    chk("R6", "low tide at reset", irq_low_tide, 1);
    t_order();
    t_full();
    t_underflow();
    t_tide();
    t_flush();
    t_ack();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule